// File: doc/BRIEF.md
# Subfield Gray-Scale Drive Sequencer

This block paces one display frame of a matrix-addressed gas-discharge panel. Each pixel has an 8-bit code. The frame is divided into eight subfields whose light output is weighted 1, 2, 4 and so on up to 128. A cell lights in exactly those subfields that match the set bits of its code, so the eye integrates the weights into a gray level. Each subfield passes through a conditioning (reset) interval, then a line-selection (address) interval, then a light-emitting (sustain) interval.

During the address interval the sequencer walks every row and every column of the panel through a combinational read port. It then presents, registered and aligned with a line strobe, the row, the column and the single code bit that belongs to the current subfield. During the sustain interval it hands a count of alternating Y/X pulse pairs to an external pulse engine. It holds that request until the engine acknowledges that the burst is finished. A new frame request that arrives mid-frame is remembered, and it takes effect only once the running sustain burst has been acknowledged.

Top module: `subfield_sequencer`

## Requirements
- R1: After reset, `phase` is 0 (idle), `subfield` is 0, and `line_strobe` and `sus_req` are low. A `frame_start` sampled in idle makes the next cycle show `phase` = 1 with `subfield` = 0.
- R2: `phase` encodes idle = 0, reset = 1, address = 2 and sustain = 3. Within each subfield the address phase is entered only from reset, and the sustain phase is entered only from address.
- R3: The reset phase of every subfield lasts exactly RESET_CYC clock cycles.
- R4: The address phase lasts exactly ROWS*COLS cycles. In its k-th cycle (k from 0), `rd_row` = k / COLS and `rd_col` = k mod COLS: rows ascend, and columns ascend within each row.
- R5: One cycle after each address read, `line_strobe` is high. In that same cycle `scan_row` and `scan_col` equal the address that was read, and `col_bit` equals bit number `subfield` of the `pix_code` returned for it. Bit i belongs to the subfield of weight 2^i.
- R6: `sus_req` is high only in the sustain phase. It rises on entry to sustain with `sus_pairs` = PAIR_SCALE * 2^`subfield`.
- R7: `sus_req` and `sus_pairs` stay unchanged until `sus_ack` is sampled high while `sus_req` is high. That sample ends the sustain phase.
- R8: Subfields run in the order 0, 1, … , 7. `subfield` is constant from the start of a subfield's reset phase until its sustain acknowledge. After the sustain of subfield 7 is acknowledged, the block returns to idle with `subfield` = 0 and stays there.
- R9: A `frame_start` seen outside idle is latched. The current subfield still completes its sustain burst in full. After that acknowledge the block restarts at subfield 0 with a reset phase, and the eight subfields then follow in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Request to begin a frame |
| rd_row | output | ROW_W | Row address of the pixel-code read port |
| rd_col | output | COL_W | Column address of the pixel-code read port |
| pix_code | input | CODE_W | Pixel code returned combinationally for rd_row/rd_col |
| phase | output | 2 | Current period: 0 idle, 1 reset, 2 address, 3 sustain |
| subfield | output | SF_W | Index of the current subfield |
| line_strobe | output | 1 | Scan strobe; row, column and data bit are valid |
| scan_row | output | ROW_W | Row being addressed |
| scan_col | output | COL_W | Column whose data bit is presented |
| col_bit | output | 1 | On/off bit of that cell for the current subfield |
| sus_req | output | 1 | Sustain burst request |
| sus_pairs | output | PAIR_W | Number of Y/X pulse pairs requested |
| sus_ack | input | 1 | Sustain engine reports the burst complete |

## Verification
The bench builds the sequencer with a 3-row by 4-column panel, a 5-cycle reset phase and two pulse pairs per weight unit. At that size a whole eight-subfield frame takes a few hundred cycles. Several complete frames therefore fit in one run, and every scan address, every code bit position and all eight pulse-pair counts are compared against values computed in the bench. The small sizes also make the restart cases cheap to reach: one new frame request lands during an address scan, and another lands while a deliberately slow acknowledge keeps a sustain burst open.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_RESET = 2'd1,
        PH_ADDR  = 2'd2,
        PH_SUST  = 2'd3
    } phase_e;
endpackage

// File: rtl/sfd_addr_scan.sv
// Row/column walker for the address phase with an aligned, registered output stage.
module sfd_addr_scan #(
    parameter int ROWS   = 480,
    parameter int COLS   = 640,
    parameter int CODE_W = 8,
    parameter int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
    parameter int COL_W  = (COLS > 1) ? $clog2(COLS) : 1,
    parameter int SF_W   = (CODE_W > 1) ? $clog2(CODE_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic [SF_W-1:0]   sf_sel,
    input  logic [CODE_W-1:0] pix_code,
    output logic [ROW_W-1:0]  rd_row,
    output logic [COL_W-1:0]  rd_col,
    output logic              last,
    output logic              strobe,
    output logic [ROW_W-1:0]  row_o,
    output logic [COL_W-1:0]  col_o,
    output logic              bit_o
);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic             strobe;
        logic [ROW_W-1:0] orow;
        logic [COL_W-1:0] ocol;
        logic             obit;
    } scan_s;

    scan_s sc_d, sc_q;

    always_comb begin
        sc_d        = sc_q;
        sc_d.strobe = active;
        if (active) begin
            // row, column and data bit captured in one register stage
            sc_d.orow = sc_q.row;
            sc_d.ocol = sc_q.col;
            sc_d.obit = pix_code[sf_sel];
            if (sc_q.col == COL_LAST) begin
                sc_d.col = '0;
                sc_d.row = (sc_q.row == ROW_LAST) ? '0 : sc_q.row + 1'b1;
            end else begin
                sc_d.col = sc_q.col + 1'b1;
            end
        end else begin
            sc_d.row = '0;
            sc_d.col = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sc_q <= '0;
        else        sc_q <= sc_d;
    end

    assign rd_row = sc_q.row;
    assign rd_col = sc_q.col;
    assign last   = active && (sc_q.row == ROW_LAST) && (sc_q.col == COL_LAST);
    assign strobe = sc_q.strobe;
    assign row_o  = sc_q.orow;
    assign col_o  = sc_q.ocol;
    assign bit_o  = sc_q.obit;

    // R5: a strobed address always lies inside the panel
    a_r5_strobe_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        sc_q.strobe |-> (sc_q.orow <= ROW_LAST && sc_q.ocol <= COL_LAST));

    // R4: counters rest at the origin whenever the scan is idle
    a_r4_origin_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (sc_q.row == '0 && sc_q.col == '0));
endmodule

// File: rtl/sfd_sus_req.sv
// Holds a sustain pulse-pair request until the pulse engine acknowledges it.
module sfd_sus_req #(
    parameter int PAIR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PAIR_W-1:0] pairs_in,
    input  logic              ack,
    output logic              req,
    output logic [PAIR_W-1:0] pairs,
    output logic              done
);
    typedef struct packed {
        logic              req;
        logic [PAIR_W-1:0] pairs;
    } sreq_s;

    sreq_s rq_d, rq_q;

    always_comb begin
        rq_d = rq_q;
        if (load) begin
            rq_d.req   = 1'b1;
            rq_d.pairs = pairs_in;
        end else if (rq_q.req && ack) begin
            rq_d.req = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rq_q <= '0;
        else        rq_q <= rq_d;
    end

    assign req   = rq_q.req;
    assign pairs = rq_q.pairs;
    assign done  = rq_q.req && ack;

    // R7: an unacknowledged request keeps both its valid and its count
    a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rq_q.req && !ack) |=> (rq_q.req && $stable(rq_q.pairs)));

    // R6: a live request never asks for zero pairs
    a_r6_nonzero_pairs: assert property (@(posedge clk) disable iff (!rst_n)
        rq_q.req |-> (rq_q.pairs != '0));
endmodule

// File: rtl/subfield_sequencer.sv
module subfield_sequencer
    import sfd_pkg::*;
#(
    parameter int CODE_W     = 8,
    parameter int ROWS       = 480,
    parameter int COLS       = 640,
    parameter int RESET_CYC  = 1000,
    parameter int PAIR_SCALE = 4,
    parameter int ROW_W      = (ROWS > 1) ? $clog2(ROWS) : 1,
    parameter int COL_W      = (COLS > 1) ? $clog2(COLS) : 1,
    parameter int SF_W       = (CODE_W > 1) ? $clog2(CODE_W) : 1,
    parameter int PAIR_W     = CODE_W + $clog2(PAIR_SCALE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    output logic [ROW_W-1:0]  rd_row,
    output logic [COL_W-1:0]  rd_col,
    input  logic [CODE_W-1:0] pix_code,
    output logic [1:0]        phase,
    output logic [SF_W-1:0]   subfield,
    output logic              line_strobe,
    output logic [ROW_W-1:0]  scan_row,
    output logic [COL_W-1:0]  scan_col,
    output logic              col_bit,
    output logic              sus_req,
    output logic [PAIR_W-1:0] sus_pairs,
    input  logic              sus_ack
);
    localparam int              RST_W    = $clog2(RESET_CYC + 1);
    localparam logic [RST_W-1:0] CNT_LAST = RST_W'(RESET_CYC - 1);
    localparam logic [SF_W-1:0]  SF_LAST  = SF_W'(CODE_W - 1);

    typedef struct packed {
        phase_e           phase;
        logic [SF_W-1:0]  sf;
        logic [RST_W-1:0] cnt;
        logic             pend;
    } seq_s;

    seq_s st_d, st_q;

    logic              scan_last;
    logic              sus_done;
    logic              sus_load;
    logic [PAIR_W-1:0] pairs_calc;

    assign sus_load   = (st_q.phase == PH_ADDR) && scan_last;
    assign pairs_calc = PAIR_W'(PAIR_SCALE) << st_q.sf;

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (frame_start) begin
                    st_d.phase = PH_RESET;
                    st_d.sf    = '0;
                    st_d.cnt   = '0;
                    st_d.pend  = 1'b0;
                end
            end
            PH_RESET: begin
                if (frame_start) st_d.pend = 1'b1;
                if (st_q.cnt == CNT_LAST) begin
                    st_d.phase = PH_ADDR;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PH_ADDR: begin
                if (frame_start) st_d.pend = 1'b1;
                if (scan_last) st_d.phase = PH_SUST;
            end
            PH_SUST: begin
                if (sus_done) begin
                    st_d.cnt = '0;
                    if (st_q.pend || frame_start) begin
                        // burst finished in full; restart the frame
                        st_d.phase = PH_RESET;
                        st_d.sf    = '0;
                        st_d.pend  = 1'b0;
                    end else if (st_q.sf == SF_LAST) begin
                        st_d.phase = PH_IDLE;
                        st_d.sf    = '0;
                    end else begin
                        st_d.phase = PH_RESET;
                        st_d.sf    = st_q.sf + 1'b1;
                    end
                end else if (frame_start) begin
                    st_d.pend = 1'b1;
                end
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    sfd_addr_scan #(
        .ROWS   (ROWS),
        .COLS   (COLS),
        .CODE_W (CODE_W),
        .ROW_W  (ROW_W),
        .COL_W  (COL_W),
        .SF_W   (SF_W)
    ) u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (st_q.phase == PH_ADDR),
        .sf_sel   (st_q.sf),
        .pix_code (pix_code),
        .rd_row   (rd_row),
        .rd_col   (rd_col),
        .last     (scan_last),
        .strobe   (line_strobe),
        .row_o    (scan_row),
        .col_o    (scan_col),
        .bit_o    (col_bit)
    );

    sfd_sus_req #(
        .PAIR_W (PAIR_W)
    ) u_sreq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sus_load),
        .pairs_in (pairs_calc),
        .ack      (sus_ack),
        .req      (sus_req),
        .pairs    (sus_pairs),
        .done     (sus_done)
    );

    assign phase    = st_q.phase;
    assign subfield = st_q.sf;

    // R2: address follows reset, sustain follows address
    a_r2_addr_from_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_ADDR && $past(st_q.phase) != PH_ADDR)
            |-> $past(st_q.phase) == PH_RESET);
    a_r2_sust_from_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_SUST && $past(st_q.phase) != PH_SUST)
            |-> $past(st_q.phase) == PH_ADDR);

    // R3: the reset counter never passes its final value
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_RESET) |-> (st_q.cnt <= CNT_LAST));

    // R6: a sustain request exists only inside the sustain phase
    a_r6_req_in_sustain: assert property (@(posedge clk) disable iff (!rst_n)
        sus_req |-> (st_q.phase == PH_SUST));

    // R8: the subfield index moves only at a sustain acknowledge
    a_r8_sf_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase != PH_IDLE && !sus_done) |=> $stable(st_q.sf));

    // R9: sustain is never left without its acknowledge
    a_r9_no_truncation: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_SUST && !sus_done) |=> (st_q.phase == PH_SUST));
endmodule

// File: tb/subfield_sequencer_tb.sv
module subfield_sequencer_tb;
    localparam int CODE_W = 8;
    localparam int ROWS   = 3;
    localparam int COLS   = 4;
    localparam int RC     = 5;
    localparam int SCALE  = 2;
    localparam int ROW_W  = $clog2(ROWS);
    localparam int COL_W  = $clog2(COLS);
    localparam int SF_W   = $clog2(CODE_W);
    localparam int PAIR_W = CODE_W + $clog2(SCALE + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 1'b0;
    logic sus_ack = 1'b0;
    logic [ROW_W-1:0] rd_row, scan_row;
    logic [COL_W-1:0] rd_col, scan_col;
    logic [CODE_W-1:0] pix_code;
    logic [1:0] phase;
    logic [SF_W-1:0] subfield;
    logic line_strobe, col_bit, sus_req;
    logic [PAIR_W-1:0] sus_pairs;

    always #5 clk = ~clk;

    function automatic logic [7:0] pix_f(int r, int c);
        return 8'(((r * COLS + c) * 23) ^ 8'hA5);
    endfunction

    assign pix_code = pix_f(int'(rd_row), int'(rd_col));

    subfield_sequencer #(
        .CODE_W(CODE_W), .ROWS(ROWS), .COLS(COLS),
        .RESET_CYC(RC), .PAIR_SCALE(SCALE)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .rd_row(rd_row), .rd_col(rd_col), .pix_code(pix_code),
        .phase(phase), .subfield(subfield), .line_strobe(line_strobe),
        .scan_row(scan_row), .scan_col(scan_col), .col_bit(col_bit),
        .sus_req(sus_req), .sus_pairs(sus_pairs), .sus_ack(sus_ack)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    int sust_seq [32];
    int n_sust = 0;
    int n_strobe = 0;
    bit auto_ack = 1;
    int ack_dly = 2;

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // per-cycle monitor: phase lengths, order, read addresses, strobed data
    initial begin
        int prev = 0, run = 0, ar = 0, ac = 0, er = 0, ec = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (int'(phase) != prev) begin
                    if (prev == 1) check(run == RC, "R3 reset length", run, RC);
                    if (prev == 2) check(run == ROWS * COLS, "R4 address length", run, ROWS * COLS);
                    if (phase == 2) check(prev == 1, "R2 address entered from", prev, 1);
                    if (phase == 3) check(prev == 2, "R2 sustain entered from", prev, 2);
                    prev = int'(phase);
                    run = 1;
                end else run++;
                if (phase == 2) begin
                    check(int'(rd_row) == ar && int'(rd_col) == ac, "R4 read address",
                          int'(rd_row) * 100 + int'(rd_col), ar * 100 + ac);
                    ac++;
                    if (ac == COLS) begin ac = 0; ar++; end
                end else begin
                    ar = 0; ac = 0;
                end
                if (line_strobe) begin
                    logic [7:0] code;
                    code = pix_f(er, ec);
                    n_strobe++;
                    check(int'(scan_row) == er && int'(scan_col) == ec, "R5 strobe address",
                          int'(scan_row) * 100 + int'(scan_col), er * 100 + ec);
                    check(col_bit == code[subfield], "R5 column bit",
                          int'(col_bit), int'(code[subfield]));
                    ec++;
                    if (ec == COLS) begin ec = 0; er++; end
                end
                if (phase == 1) begin er = 0; ec = 0; end
            end
        end
    end

    // sustain pulse-engine model
    initial begin
        bit seen = 0;
        int waited = 0;
        int held = 0;
        forever begin
            @(negedge clk);
            sus_ack = 1'b0;
            if (rst_n && sus_req) begin
                if (!seen) begin
                    seen = 1; waited = 0; held = int'(sus_pairs);
                    if (n_sust < 32) sust_seq[n_sust] = int'(subfield);
                    n_sust++;
                    check(int'(sus_pairs) == (SCALE << subfield), "R6 pair count",
                          int'(sus_pairs), SCALE << subfield);
                    check(phase == 3, "R6 request phase", int'(phase), 3);
                end else begin
                    check(int'(sus_pairs) == held, "R7 pairs held", int'(sus_pairs), held);
                end
                if (auto_ack && waited >= ack_dly) sus_ack = 1'b1;
                waited++;
            end else seen = 0;
        end
    end

    task automatic pulse_start();
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
    endtask

    task automatic wait_idle(string tag);
        int k = 0;
        while (phase != 0 && k < 20000) begin @(negedge clk); k++; end
        check(phase == 0, tag, int'(phase), 0);
    endtask

    task automatic t_reset_state();
        check(phase == 0, "R1 idle after reset", int'(phase), 0);
        check(subfield == 0, "R1 subfield after reset", int'(subfield), 0);
        check(!line_strobe && !sus_req, "R1 strobe/request low", int'(line_strobe) + int'(sus_req), 0);
    endtask

    task automatic t_full_frame();
        n_sust = 0; n_strobe = 0;
        pulse_start();
        check(phase == 1, "R1 start enters reset", int'(phase), 1);
        check(subfield == 0, "R1 start subfield", int'(subfield), 0);
        wait_idle("R8 frame ends idle");
        check(n_sust == 8, "R8 subfield count", n_sust, 8);
        for (int i = 0; i < 8; i++) check(sust_seq[i] == i, "R8 subfield order", sust_seq[i], i);
        check(n_strobe == 8 * ROWS * COLS, "R5 strobe count", n_strobe, 8 * ROWS * COLS);
        check(subfield == 0, "R8 subfield after frame", int'(subfield), 0);
        repeat (20) @(negedge clk);
        check(phase == 0 && !sus_req, "R8 stays idle", int'(phase), 0);
    endtask

    task automatic t_restart_in_address();
        int k = 0;
        n_sust = 0;
        pulse_start();
        while (!(phase == 2 && subfield == 2) && k < 5000) begin @(negedge clk); k++; end
        pulse_start();
        wait_idle("R9 restart frame ends idle");
        check(n_sust == 11, "R9 burst count with restart", n_sust, 11);
        check(sust_seq[2] == 2, "R9 interrupted subfield completes", sust_seq[2], 2);
        check(sust_seq[3] == 0, "R9 restart at subfield 0", sust_seq[3], 0);
        check(sust_seq[10] == 7, "R9 restarted frame reaches last", sust_seq[10], 7);
    endtask

    task automatic t_restart_in_sustain();
        int k = 0;
        n_sust = 0;
        ack_dly = 25;
        pulse_start();
        while (!(phase == 3 && subfield == 1 && sus_req) && k < 5000) begin @(negedge clk); k++; end
        pulse_start();
        repeat (10) @(negedge clk);
        check(sus_req == 1'b1, "R7 request held without ack", int'(sus_req), 1);
        check(phase == 3 && subfield == 1, "R9 sustain not truncated",
              int'(phase) * 10 + int'(subfield), 31);
        wait_idle("R9 sustain restart ends idle");
        ack_dly = 2;
        check(n_sust == 10, "R9 burst count", n_sust, 10);
        check(sust_seq[1] == 1 && sust_seq[2] == 0, "R9 order after sustain restart",
              sust_seq[1] * 10 + sust_seq[2], 10);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_full_frame();
        t_restart_in_address();
        t_restart_in_sustain();
        t_full_frame();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule